// File: doc/BRIEF.md
# Sequential 16-bit Integer Square Root

This unit computes the floor square root of a 16-bit unsigned value over many clock cycles. It uses the powers-of-four digit method. A single shared ALU does all the arithmetic. Four working registers hold the state of the loop: two accumulators and two single-entry holding buffers. The holding buffers serve as extra storage and trade places with the accumulators around each compare.

The host reaches the unit through a small register port with two addresses. Address 0 is the data register. Address 1 is the control and status register. To run a computation, the host:

1. writes the argument to the data register while the unit is idle;
2. writes the value 0x0001 to the control register;
3. polls the status bits until the done flag is set;
4. reads the 8-bit root back from the data register.

Only one computation runs at a time.

The state code is four bits wide. Its low three bits pick one of eight ALU operations, so states that need the same operation share those bits. Every pass tests whether the remainder is at least result plus weight, and a single subtraction does that test. The carry out of the subtraction picks the branch. The same difference becomes the new remainder when the test passes.

Top module: `isqrt16`

## Requirements
- R1: While the unit is idle, a write to address 0 loads the argument. A read of address 0 returns the last value written there until a computation starts.
- R2: A write of exactly 0x0001 to address 1 while idle starts a computation. A write of any other value to address 1 starts nothing.
- R3: The value read from address 0 after completion equals floor(sqrt(argument)) for every 16-bit argument. This includes 0→0, 1→1, 256→16, 65025→255 and 65535→255.
- R4: The weight starts at 1<<14 and is not scaled to the argument, so exactly 8 passes run. The done flag rises 49 + popcount(root) clock edges after the edge that accepted the start.
- R5: The busy flag is 1 from the edge after the start until the last state, then returns to 0. The done flag rises on the same edge that busy falls. A new start clears done. Busy and done are never 1 together.
- R6: While busy, writes to either address are ignored. The result and the completion time are unchanged.
- R7: After reset, busy and done are 0 and the data register reads 0.
- R8: A read of address 1 returns busy in bit 0 and done in bit 1, with all other bits 0.
- R9: The result occupies bits 7:0 of the data register, and bits 15:8 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects data, 1 selects control/status |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the addressed register (combinational) |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Result available in the data register |

## Verification
The bench targets three groups of inputs:

- Perfect squares next to their neighbours, such as 255, 256, 65024 and 65025. A wrong carry sense at the compare, where "at least" is treated as "greater than", would report one less than the true root on exact squares.
- The extremes 0 and 65535, where every pass goes the same way. A branch that leaves the registers in a different arrangement would scramble the result there.
- Completion times, checked against the popcount rule. A missing or extra shift state on either branch would shift the latency.

The bench also writes to both addresses during a run. A unit that accepts these writes would return the second argument's root or restart the run.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,  // accumulators from constants, buffer 1 open to host
    OP_SUM  = 3'd1,  // stash weight, form result+weight
    OP_XCH  = 3'd2,  // swap accumulator 1 with buffer 1
    OP_SUB  = 3'd3,  // trial subtract, keep on no borrow
    OP_ADD2 = 3'd4,  // result += weight<<1
    OP_SHR  = 3'd5,  // result >>= 1, weight restored
    OP_QSHR = 3'd6,  // weight >>= 2
    OP_FIN  = 3'd7   // result into buffer 1
  } alu_op_e;

  // low three bits are the ALU operation
  typedef enum logic [3:0] {
    ST_IDLE  = 4'b0000,
    ST_SUM   = 4'b0001,
    ST_SWAPA = 4'b0010,
    ST_CMP   = 4'b0011,
    ST_ADD2  = 4'b0100,
    ST_SHRT  = 4'b0101,
    ST_QSHR  = 4'b0110,
    ST_FIN   = 4'b0111,
    ST_SWAPB = 4'b1010,
    ST_SHRN  = 4'b1101
  } state_e;
endpackage

// File: rtl/isqrt_dp.sv
module isqrt_dp
  import isqrt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alu_op_e      op_i,
  input  logic         host_wr_i,
  input  logic [W-1:0] host_data_i,
  output logic         ge_o,
  output logic         wlast_o,
  output logic [W-1:0] f1_o
);
  localparam logic [W-1:0] INIT_WEIGHT = W'(1) << (W - 2);

  logic [W-1:0] a0_q, a1_q, f0_q, f1_q;
  logic [W:0]   diff_w;

  assign diff_w  = {1'b0, a1_q} - {1'b0, a0_q};
  assign ge_o    = ~diff_w[W];
  assign wlast_o = (a0_q[W-1:2] == '0);
  assign f1_o    = f1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a0_q <= '0;
      a1_q <= '0;
      f0_q <= '0;
      f1_q <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: begin
          a0_q <= INIT_WEIGHT;
          a1_q <= '0;
          if (host_wr_i) f1_q <= host_data_i;
        end
        OP_SUM: begin
          f0_q <= a0_q;
          a0_q <= a0_q + a1_q;
        end
        OP_XCH: begin
          a1_q <= f1_q;
          f1_q <= a1_q;
        end
        OP_SUB:  if (ge_o) a1_q <= diff_w[W-1:0];
        OP_ADD2: a1_q <= a1_q + (f0_q << 1);
        OP_SHR: begin
          a1_q <= a1_q >> 1;
          a0_q <= f0_q;
        end
        OP_QSHR: a0_q <= a0_q >> 2;
        OP_FIN:  f1_q <= a1_q;
        default: ;
      endcase
    end
  end

  p_weight_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SUM |-> $countones(a0_q) == 1);
  p_root_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_FIN |-> a1_q[W-1:W/2] == '0);
  p_f1_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_LOAD && op_i != OP_XCH && op_i != OP_FIN) |=> $stable(f1_q));
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    ge_i,
  input  logic    wlast_i,
  output alu_op_e op_o,
  output logic    busy_o,
  output logic    done_o
);
  state_e state_q, state_d;
  logic   taken_q, done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_SUM;
      ST_SUM:   state_d = ST_SWAPA;
      ST_SWAPA: state_d = ST_CMP;
      ST_CMP:   state_d = ST_SWAPB;
      ST_SWAPB: state_d = taken_q ? ST_ADD2 : ST_SHRN;
      ST_ADD2:  state_d = ST_SHRT;
      ST_SHRT,
      ST_SHRN:  state_d = ST_QSHR;
      ST_QSHR:  state_d = wlast_i ? ST_FIN : ST_SUM;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      taken_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CMP) taken_q <= ge_i;
      if (state_q == ST_IDLE && start_i) done_q <= 1'b0;
      else if (state_q == ST_FIN)        done_q <= 1'b1;
    end
  end

  assign op_o   = alu_op_e'(state_q[2:0]);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  p_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_finish_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FIN |=> (done_o && !busy_o));
  p_run_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_FIN) |=> busy_o);
endmodule

// File: rtl/isqrt16.sv
module isqrt16
  import isqrt_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [DATA_W-1:0] START_CMD = DATA_W'(1);

  alu_op_e            op;
  logic               start, host_wr, ge, wlast, busy, done;
  logic [DATA_W-1:0]  f1;

  assign start   = wr_i &  addr_i & (wdata_i == START_CMD) & ~busy;
  assign host_wr = wr_i & ~addr_i & ~busy;

  isqrt_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ge_i    (ge),
    .wlast_i (wlast),
    .op_o    (op),
    .busy_o  (busy),
    .done_o  (done)
  );

  isqrt_dp #(.W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .host_wr_i   (host_wr),
    .host_data_i (wdata_i),
    .ge_o        (ge),
    .wlast_o     (wlast),
    .f1_o        (f1)
  );

  assign rdata_o = addr_i ? {{(DATA_W-2){1'b0}}, done, busy} : f1;
  assign busy_o  = busy;
  assign done_o  = done;

  p_host_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op == OP_SUB) |=> $stable(f1));
endmodule

// File: tb/isqrt16_tb.sv
module isqrt16_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, done;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isqrt16 u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  function automatic int ref_sqrt(int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic int popc(int x);
    int n = 0;
    for (int i = 0; i < 16; i++) n += (x >> i) & 1;
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic a, logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(logic a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(int x, string req);
    int lat, v;
    int r = ref_sqrt(x);
    reg_wr(1'b0, 16'(x));
    reg_wr(1'b1, 16'h0001);
    wait_done(lat);
    rd(1'b0, v);
    check({req, " R3 root"}, v & 255, r);
    check("R9 upper byte", v >> 8, 0);
    check("R4 latency", lat, 49 + popc(r));
  endtask

  initial begin
    int v, lat, r;
    void'($urandom(32'h1d2c_3b4a));
    #(CLK_PERIOD * 2 + 3);
    rst_ni = 1'b1;
    // R7 reset state
    @(negedge clk);
    check("R7 busy", int'(busy), 0);
    check("R7 done", int'(done), 0);
    rd(1'b0, v); check("R7 data", v, 0);
    rd(1'b1, v); check("R8 status at reset", v, 0);

    // R1 argument readback before start
    reg_wr(1'b0, 16'h1234);
    rd(1'b0, v); check("R1 readback", v, 16'h1234);

    // R2 wrong command values start nothing
    reg_wr(1'b1, 16'h0002);
    reg_wr(1'b1, 16'h0101);
    repeat (3) @(negedge clk);
    check("R2 no start busy", int'(busy), 0);
    rd(1'b0, v); check("R2 argument kept", v, 16'h1234);

    // R5 busy/done timing and R8 status
    reg_wr(1'b1, 16'h0001);
    check("R5 busy after start", int'(busy), 1);
    check("R5 done cleared", int'(done), 0);
    rd(1'b1, v); check("R8 status busy", v, 1);
    wait_done(lat);
    check("R5 busy low at done", int'(busy), 0);
    rd(1'b1, v); check("R8 status done", v, 2);
    rd(1'b0, v); check("R3 root 0x1234", v, ref_sqrt(16'h1234));
    reg_wr(1'b0, 16'd100);
    reg_wr(1'b1, 16'h0001);
    check("R5 restart clears done", int'(done), 0);
    wait_done(lat);
    rd(1'b0, v); check("R3 root 100", v, 10);

    // R3 directed corners
    run_one(0, "zero");
    run_one(1, "one");
    run_one(65535, "max");
    run_one(256, "sq256");
    run_one(255, "below256");
    run_one(65025, "sq65025");
    run_one(65024, "below65025");
    run_one(2, "two");
    run_one(3, "three");
    run_one(4, "four");
    run_one(16384, "quarter");

    // R6 writes during a run are ignored
    reg_wr(1'b0, 16'd50000);
    reg_wr(1'b1, 16'h0001);
    lat = 0;
    while (!done && lat < 200) begin
      wr = (lat == 10 || lat == 11);
      addr = (lat == 11);
      wdata = (lat == 10) ? 16'd9 : 16'h0001;
      @(negedge clk);
      lat++;
    end
    wr = 1'b0;
    r = ref_sqrt(50000);
    rd(1'b0, v); check("R6 root unaffected", v, r);
    check("R6 latency unaffected", lat, 49 + popc(r));

    // random sweep
    for (int i = 0; i < 1400; i++) run_one(int'($urandom() & 32'hffff), "random");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule